// File: doc/BRIEF.md
# Keypad Matrix Scanner with Chord Qualification

This block reads an eight-by-eight key switch matrix. It drives one column line at a time and samples the eight row lines, which are pulled low and read high where a pressed key joins them to the driven column. One full pass over the columns gives a 64-bit snapshot. When a complete pass finds no key, the scanner halts and drives every column at once. Any row going high then wakes it, and it starts again at the first column.

A qualifier consumes one snapshot per pass. A lone key must stay present for a start-up count of passes before it is accepted. It then raises a one-cycle request with an eight-bit code and holds a level flag until the keys are released. Two keys seen before acceptance block all output until every key is lifted. One head key may form a chord with one of three partner keys. The chord counts only when the partner arrives after the head key has been held for a long count of passes, and the partner must then pass the start-up count itself. A chord reports the partner's code with a chord flag bit set. The code's most significant bit is not scanned; it is copied from a configuration pin when the request is made.

Time is counted in system-clock ticks. Parameters give the tick divider, the ticks per column, and the two thresholds in whole scan passes, so a bench can run with short values.

Top module: `keymatrix_chord_scan`

## Requirements
- R1: While scanning, exactly one bit of `col_drive` is high. Columns follow in order 0 to 7 and back to 0, and each column stays driven for TICK_DIV*COL_TICKS clock cycles.
- R2: After reset, and after any complete pass that sees no key, all eight columns are driven high (halt). A high row while halted starts a pass at column 0 on the next clock.
- R3: A key is accepted only after it is the sole key in START_SCANS consecutive pass snapshots. A shorter press gives no request.
- R4: For a key at column c (0..7) and row r (0..7), code bits [1:0] = r mod 4, bits [4:2] = c, bit 5 = 0, and bit 6 = 1 exactly when r >= 4.
- R5: `key_req` is high for one clock per accepted key or chord, one clock after the pass that qualifies it. `key_hold` is high from that clock on.
- R6: `key_hold` falls one clock after the first complete pass that contains no key.
- R7: If two or more keys appear in a pass before any key is accepted, no request is made until a pass sees no key at all.
- R8: Head key (c=5, r=0) forms a chord with a partner at c=5, r=1..3. The partner must first appear once the head has been held alone for at least CHORD_SCANS passes, and the pair must then stay for START_SCANS passes. The request then carries the partner's code with bit 5 set.
- R9: After a key has been accepted, any other added key that is not a valid late partner gives no further request. `key_hold` stays high until release.
- R10: Code bit 7 equals `cfg_msb` as sampled in the clock that raises `key_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_in | input | 8 | Row sense lines, high where a pressed key meets a driven column |
| cfg_msb | input | 1 | Static value for code bit 7 |
| col_drive | output | 8 | Column drive, one-hot while scanning, all ones while halted |
| key_req | output | 1 | One-cycle request for a qualified key or chord |
| key_code | output | 8 | Code that goes with the request, held until the next request |
| key_hold | output | 1 | High while the reported key or chord is still pressed |

## Verification
The bench targets the points where a qualifier can be off by one pass. These are a press that lasts just under the start-up count, two keys arriving inside the same pass, and a chord partner added before or after the long threshold. An early-partner bug would emit a second code that should not exist, and a late-partner bug would drop the chord code. It also checks the column dwell time and the fall into halt after release. A scanner that never halts would leave a single column driven, and a hold flag that lags would stay high past the first empty pass. The code layout is checked with keys in the upper row group and in the last column, where a swapped column/row field or a missing bit 6 shows directly.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  localparam int NCOL    = 8;
  localparam int NROW    = 8;
  localparam int NKEY    = NCOL * NROW;
  localparam int KIDX_W  = $clog2(NKEY);
  localparam int COL_W   = $clog2(NCOL);
  localparam int CODE_W  = 7;
  // head key of the chord group: column 5, row 0; partners are rows 1..3
  localparam logic [KIDX_W-1:0] CHORD_HEAD = KIDX_W'(5 * NROW);
  localparam int NPARTNER = 3;

  typedef enum logic [2:0] {
    Q_IDLE, Q_QUAL, Q_HELD, Q_CHORD, Q_LOCK, Q_REJ
  } qstate_e;

  // physical index = column*NROW + row ; code = {row>=4, 0, column, row mod 4}
  function automatic logic [CODE_W-1:0] phys_code(input logic [KIDX_W-1:0] p);
    logic [2:0] r;
    logic [2:0] c;
    r = p[2:0];
    c = p[5:3];
    return {r[2], 1'b0, c, r[1:0]};
  endfunction

  function automatic logic [1:0] key_count(input logic [NKEY-1:0] s);
    int n;
    n = 0;
    for (int i = 0; i < NKEY; i++) n += int'(s[i]);
    return (n > 3) ? 2'd3 : 2'(n);
  endfunction

  function automatic logic [KIDX_W-1:0] low_key(input logic [NKEY-1:0] s);
    logic [KIDX_W-1:0] r;
    r = '0;
    for (int i = NKEY - 1; i >= 0; i--) if (s[i]) r = KIDX_W'(i);
    return r;
  endfunction

  function automatic logic [KIDX_W-1:0] high_key(input logic [NKEY-1:0] s);
    logic [KIDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NKEY; i++) if (s[i]) r = KIDX_W'(i);
    return r;
  endfunction

  function automatic logic is_partner(input logic [KIDX_W-1:0] k);
    return (k > CHORD_HEAD) && (k <= CHORD_HEAD + KIDX_W'(NPARTNER));
  endfunction
endpackage

// File: rtl/kscan_tick.sv
module kscan_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!en || tick)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R1: ticks never come back to back when the divider exceeds one
      assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/kscan_colscan.sv
module kscan_colscan
  import kscan_pkg::*;
#(
  parameter int TICK_DIV  = 1000,
  parameter int COL_TICKS = 125
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NROW-1:0] row_in,
  output logic [NCOL-1:0] col_drive,
  output logic            scan_done,
  output logic [NKEY-1:0] snapshot
);
  localparam int TW = (COL_TICKS > 1) ? $clog2(COL_TICKS) : 1;

  logic            halted;
  logic [COL_W-1:0] col;
  logic [TW-1:0]   tcnt;
  logic [NKEY-1:0] acc;
  logic [NKEY-1:0] merged;
  logic            tick;
  logic            col_end;
  logic            last_col;

  kscan_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (!halted),
    .tick (tick)
  );

  assign col_end  = tick && (tcnt == TW'(COL_TICKS - 1));
  assign last_col = (col == COL_W'(NCOL - 1));

  always_comb begin
    merged = acc;
    merged[int'(col) * NROW +: NROW] = row_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted    <= 1'b1;
      col       <= '0;
      tcnt      <= '0;
      acc       <= '0;
      scan_done <= 1'b0;
      snapshot  <= '0;
    end else begin
      scan_done <= 1'b0;
      if (halted) begin
        if (|row_in) begin
          halted <= 1'b0;
          col    <= '0;
          tcnt   <= '0;
        end
      end else if (col_end) begin
        tcnt <= '0;
        acc  <= merged;
        if (last_col) begin
          scan_done <= 1'b1;
          snapshot  <= merged;
          col       <= '0;
          halted    <= (merged == '0);
        end else begin
          col <= col + 1'b1;
        end
      end else if (tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < NCOL; g++) begin : g_drv
      assign col_drive[g] = halted || (col == COL_W'(g));
    end
  endgenerate

  // R1: drive is one column or, when halted, all of them
  assert_drive_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(col_drive) || (&col_drive));
  // R2: a row seen while halted starts scanning at column 0
  assert_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((&col_drive) && (|row_in)) |=> (col_drive == NCOL'(1)));
  // R2: an empty pass leaves the scanner halted
  assert_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && (snapshot == '0)) |-> (&col_drive));
endmodule

// File: rtl/kscan_qual.sv
module kscan_qual
  import kscan_pkg::*;
#(
  parameter int START_SCANS = 4,
  parameter int CHORD_SCANS = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_done,
  input  logic [NKEY-1:0] snapshot,
  input  logic            cfg_msb,
  output logic            key_req,
  output logic [7:0]      key_code,
  output logic            key_hold
);
  localparam int MAXV  = (START_SCANS > CHORD_SCANS) ? START_SCANS : CHORD_SCANS;
  localparam int AGE_W = $clog2(MAXV + 2);
  localparam logic [AGE_W-1:0] START_V = AGE_W'(START_SCANS);
  localparam logic [AGE_W-1:0] CHORD_V = AGE_W'(CHORD_SCANS);

  qstate_e           st;
  logic [KIDX_W-1:0] key;
  logic [KIDX_W-1:0] sec;
  logic [AGE_W-1:0]  age;
  logic [AGE_W-1:0]  age_inc;
  logic [1:0]        cnt;
  logic [KIDX_W-1:0] lo;
  logic [KIDX_W-1:0] hi;
  logic              alone;
  logic              chord_pair;

  assign cnt        = key_count(snapshot);
  assign lo         = low_key(snapshot);
  assign hi         = high_key(snapshot);
  assign alone      = (cnt == 2'd1) && (lo == key);
  assign chord_pair = (cnt == 2'd2) && (key == CHORD_HEAD) && (lo == CHORD_HEAD) && is_partner(hi);
  assign age_inc    = age + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= Q_IDLE;
      key      <= '0;
      sec      <= '0;
      age      <= '0;
      key_req  <= 1'b0;
      key_code <= '0;
    end else begin
      key_req <= 1'b0;
      if (scan_done) begin
        case (st)
          Q_IDLE: begin
            if (cnt == 2'd1) begin
              st  <= Q_QUAL;
              key <= lo;
              age <= AGE_W'(1);
            end else if (cnt != 2'd0) begin
              st <= Q_REJ;
            end
          end
          Q_QUAL: begin
            if (cnt == 2'd0) st <= Q_IDLE;
            else if (alone) begin
              age <= age_inc;
              if (age_inc == START_V) begin
                st       <= Q_HELD;
                key_req  <= 1'b1;
                key_code <= {cfg_msb, phys_code(key)};
              end
            end else st <= Q_REJ;
          end
          Q_HELD: begin
            if (cnt == 2'd0) st <= Q_IDLE;
            else if (alone) begin
              if (age < CHORD_V) age <= age_inc;
            end else if (chord_pair && (age >= CHORD_V)) begin
              st  <= Q_CHORD;
              sec <= hi;
              age <= AGE_W'(1);
            end else st <= Q_LOCK;
          end
          Q_CHORD: begin
            if (cnt == 2'd0) st <= Q_IDLE;
            else if (chord_pair && (hi == sec)) begin
              age <= age_inc;
              if (age_inc == START_V) begin
                st       <= Q_LOCK;
                key_req  <= 1'b1;
                key_code <= {cfg_msb, phys_code(sec) | 7'h20};
              end
            end else st <= Q_LOCK;
          end
          default: begin
            if (cnt == 2'd0) st <= Q_IDLE;
          end
        endcase
      end
    end
  end

  assign key_hold = (st == Q_HELD) || (st == Q_CHORD) || (st == Q_LOCK);

  // R5: a request lasts one clock
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_req |=> !key_req);
  // R5: the hold flag is up together with the request
  assert_req_with_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_req |-> key_hold);
  // R3: requests only follow a finished pass
  assert_req_on_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_req |-> $past(scan_done));
  // R10: top code bit follows the configuration pin
  assert_msb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_req |-> (key_code[7] == $past(cfg_msb)));
  // R6: an empty pass clears the hold flag
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && (snapshot == '0)) |=> (!key_hold && !key_req));
  // R8: the chord flag only comes out of chord qualification
  assert_chord_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_req && key_code[5]) |-> ($past(st) == Q_CHORD));
  // R7: a multi-key pass before acceptance never produces a request
  assert_multi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && (cnt >= 2'd2) && ((st == Q_IDLE) || (st == Q_QUAL))) |=> !key_req);
endmodule

// File: rtl/keymatrix_chord_scan.sv
module keymatrix_chord_scan
  import kscan_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int COL_TICKS   = 125,
  parameter int START_SCANS = 4,
  parameter int CHORD_SCANS = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] row_in,
  input  logic       cfg_msb,
  output logic [7:0] col_drive,
  output logic       key_req,
  output logic [7:0] key_code,
  output logic       key_hold
);
  logic            scan_done;
  logic [NKEY-1:0] snapshot;

  kscan_colscan #(
    .TICK_DIV (TICK_DIV),
    .COL_TICKS(COL_TICKS)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_in   (row_in),
    .col_drive(col_drive),
    .scan_done(scan_done),
    .snapshot (snapshot)
  );

  kscan_qual #(
    .START_SCANS(START_SCANS),
    .CHORD_SCANS(CHORD_SCANS)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_done(scan_done),
    .snapshot (snapshot),
    .cfg_msb  (cfg_msb),
    .key_req  (key_req),
    .key_code (key_code),
    .key_hold (key_hold)
  );
endmodule

// File: tb/sim_keymatrix_chord_scan.sv
module sim_keymatrix_chord_scan;
  localparam int TDIV = 2;
  localparam int CTK  = 2;
  localparam int STRT = 3;
  localparam int CHRD = 8;
  localparam int SCAN = 8 * TDIV * CTK;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] row_in;
  logic       cfg_msb = 1'b0;
  logic [7:0] col_drive;
  logic       key_req;
  logic [7:0] key_code;
  logic       key_hold;

  logic [63:0] keys = '0;   // bit c*8+r : key at column c, row r is down
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [7:0] req_log[$];

  always #5 clk = ~clk;

  keymatrix_chord_scan #(
    .TICK_DIV(TDIV), .COL_TICKS(CTK), .START_SCANS(STRT), .CHORD_SCANS(CHRD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .row_in(row_in), .cfg_msb(cfg_msb),
    .col_drive(col_drive), .key_req(key_req), .key_code(key_code), .key_hold(key_hold)
  );

  // switch matrix: a row is high when a down key meets a driven column
  always_comb begin
    row_in = '0;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++)
        if (keys[c*8+r] && col_drive[c]) row_in[r] = 1'b1;
  end

  function automatic int ref_code(int p);
    int r;
    int c;
    r = p % 8;
    c = p / 8;
    return ((r >= 4) ? 64 : 0) + c * 4 + (r % 4);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model, compared every clock ----------------
  int   mst = 0;      // 0 idle 1 qual 2 held 3 chord 4 lock 5 reject
  int   mkey, msec, mage, mage2;
  bit   exp_req = 0, exp_hold = 0;
  int   exp_code = 0;
  logic [7:0]  prev_col = 8'hFF;
  logic [7:0]  prev_row = '0;
  logic [63:0] macc = '0;

  task automatic model_pass(logic [63:0] s);
    int n, lo, hi;
    n = $countones(s);
    lo = -1; hi = -1;
    for (int i = 0; i < 64; i++) if (s[i]) begin if (lo < 0) lo = i; hi = i; end
    case (mst)
      0: if (n == 1) begin mst = 1; mkey = lo; mage = 1; end
         else if (n >= 2) mst = 5;
      1: if (n == 0) mst = 0;
         else if (n == 1 && lo == mkey) begin
           mage++;
           if (mage == STRT) begin
             mst = 2; exp_req = 1; exp_code = (cfg_msb ? 128 : 0) + ref_code(mkey);
           end
         end else mst = 5;
      2: if (n == 0) mst = 0;
         else if (n == 1 && lo == mkey) begin if (mage < CHRD) mage++; end
         else if (n == 2 && mkey == 40 && lo == 40 && hi >= 41 && hi <= 43 && mage >= CHRD) begin
           mst = 3; msec = hi; mage2 = 1;
         end else mst = 4;
      3: if (n == 0) mst = 0;
         else if (n == 2 && lo == 40 && hi == msec) begin
           mage2++;
           if (mage2 == STRT) begin
             mst = 4; exp_req = 1; exp_code = (cfg_msb ? 128 : 0) + 32 + ref_code(msec);
           end
         end else mst = 4;
      default: if (n == 0) mst = 0;
    endcase
    exp_hold = (mst == 2 || mst == 3 || mst == 4);
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check(key_req === exp_req, "R5 key_req", int'(key_req), int'(exp_req));
      check(key_hold === exp_hold, "R6 key_hold", int'(key_hold), int'(exp_hold));
      if (exp_req) check(key_code === 8'(exp_code), "R4 key_code", int'(key_code), exp_code);
      if (key_req) req_log.push_back(key_code);
    end
    exp_req = 0;
    if (!rst_n) begin
      mst = 0; exp_hold = 0; prev_col = 8'hFF; prev_row = '0;
    end else begin
      if ($onehot(prev_col) && col_drive !== prev_col) begin
        int c;
        c = $clog2(prev_col);
        macc[c*8 +: 8] = prev_row;
        if (c == 7) model_pass(macc);
      end
      prev_col = col_drive;
      prev_row = row_in;
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic scans(int n);
    repeat (n * SCAN) @(negedge clk);
  endtask

  task automatic settle();
    keys = '0;
    scans(3);
  endtask

  task automatic check_log(string tag, int n, int c0, int c1);
    check(req_log.size() == n, {tag, " request count"}, req_log.size(), n);
    if (req_log.size() == n && n >= 1) check(req_log[0] == 8'(c0), {tag, " first code"}, int'(req_log[0]), c0);
    if (req_log.size() == n && n >= 2) check(req_log[1] == 8'(c1), {tag, " second code"}, int'(req_log[1]), c1);
    req_log.delete();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(col_drive == 8'hFF, "R2 reset drive", int'(col_drive), 8'hFF);
    check(key_hold == 1'b0 && key_req == 1'b0, "R5 reset outputs", int'({key_req, key_hold}), 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check(col_drive == 8'hFF, "R2 idle stays halted", int'(col_drive), 8'hFF);

    // R1 R3 R4: K1 at column 0 row 0, long press; dwell per column
    keys[0] = 1'b1;
    for (int i = 0; i < 100 && col_drive != 8'h01; i++) @(negedge clk);
    begin
      int dwell;
      dwell = 0;
      while (col_drive == 8'h01 && dwell < 100) begin dwell++; @(negedge clk); end
      check(dwell == TDIV * CTK, "R1 column dwell", dwell, TDIV * CTK);
      check(col_drive == 8'h02, "R1 next column", int'(col_drive), 8'h02);
    end
    scans(10);
    check(key_hold == 1'b1, "R5 hold while pressed", int'(key_hold), 1);
    keys = '0;
    scans(2);
    check(key_hold == 1'b0, "R6 hold after release", int'(key_hold), 0);
    check(col_drive == 8'hFF, "R2 halt after release", int'(col_drive), 8'hFF);
    check_log("R3 R4 K1", 1, 8'h00, 0);

    // R3: short press (column 1 row 0) gives nothing
    keys[8] = 1'b1;
    repeat (40) @(negedge clk);
    settle();
    check_log("R3 short press", 0, 0, 0);

    // R4 R10: column 7 row 7 with msb set
    cfg_msb = 1'b1;
    keys[63] = 1'b1;
    scans(6);
    settle();
    cfg_msb = 1'b0;
    check_log("R4 R10 last key", 1, 8'hDF, 0);

    // R4: column 0 row 4 (upper row group)
    keys[4] = 1'b1;
    scans(6);
    settle();
    check_log("R4 upper group", 1, 8'h40, 0);

    // R7: two keys at once
    keys[2] = 1'b1; keys[17] = 1'b1;
    scans(4);
    check(key_hold == 1'b0, "R7 no hold on double press", int'(key_hold), 0);
    scans(4);
    settle();
    check_log("R7 double press", 0, 0, 0);

    // R8: late partner (column 5 row 1)
    keys[40] = 1'b1;
    scans(12);
    keys[41] = 1'b1;
    scans(6);
    settle();
    check_log("R8 late chord", 2, 8'h14, 8'h35);

    // R9: early partner (column 5 row 2) is ignored
    keys[40] = 1'b1;
    scans(5);
    keys[42] = 1'b1;
    scans(6);
    check(key_hold == 1'b1, "R9 hold kept after early partner", int'(key_hold), 1);
    settle();
    check_log("R9 early chord", 1, 8'h14, 0);

    // R8 R10: late partner (column 5 row 3) with msb set
    cfg_msb = 1'b1;
    keys[40] = 1'b1;
    scans(12);
    keys[43] = 1'b1;
    scans(6);
    settle();
    cfg_msb = 1'b0;
    check_log("R8 R10 chord msb", 2, 8'h94, 8'hB7);

    // R9: a non-partner key added late
    keys[10] = 1'b1;
    scans(12);
    keys[57] = 1'b1;
    scans(6);
    check(key_hold == 1'b1, "R9 hold with extra key", int'(key_hold), 1);
    settle();
    check_log("R9 extra key", 1, 8'h06, 0);

    finished = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      finish_run();
    end
  end
endmodule